// File: doc/BRIEF.md
# Sound RAM Transfer FIFO Controller

This block carries 16-bit halfwords between a host-side register interface and a 512 KiB sound memory. A 32-entry FIFO sits between them. The host picks a transfer direction through a 2-bit mode field in a control register. It loads a start address expressed in 8-byte units. It then either pushes data into the FIFO, by hand or from a DMA engine, or lets the block fill the FIFO from memory so that a DMA engine can pop it.

The memory side runs at a fixed rate. A pacing counter allows one halfword between FIFO and memory every 32 clock cycles. Each access advances the memory address by one halfword, and the address wraps at the end of the memory. A status word reports the mirrored mode bits, a busy flag, separate DMA write and read request flags, and their combination. Writing the stopped mode flushes everything in flight.

The memory is modelled as a synchronous halfword port with a one-cycle read latency.

Top module: `sndram_xfer`

## Requirements
- R1: After reset the status word is 0x0000, no memory access is issued and the FIFO is empty.
- R2: Status bits 5:0 always equal bits 5:0 of the last control write. Status bits 15:11 and bit 6 read zero.
- R3: The mode is control bits 5:4, encoded 0 = stopped, 1 = host write, 2 = DMA write, 3 = DMA read. In modes 1 and 2, `data_wr` pushes `data_wdata` into the FIFO. A push is accepted if the FIFO is not full, or if it is full and a halfword leaves in the same cycle. Otherwise the push is dropped. Every accepted halfword is written to memory in push order with `ram_we` = 1.
- R4: The first memory access happens exactly 32 cycles after the FIFO work becomes pending. While work stays pending, consecutive accesses are exactly 32 cycles apart.
- R5: Loading the start register with value S sets the halfword address to S*4 (byte address S*8). Each access increments the address by one, and the address wraps from 0x3FFFF to 0.
- R6: In mode 3 the block reads memory at consecutive addresses into the FIFO while it has room. `data_rdata` shows the oldest entry, and `data_rd` removes it.
- R7: Busy (status bit 10) is set in modes 1 and 2 while the FIFO is not empty. In mode 3 it is set while the FIFO is not full. In mode 0 it is clear.
- R8: DMA write request (bit 9) is set only in mode 2 while the FIFO is not full. DMA read request (bit 8) is set only in mode 3 while the FIFO is not empty. Bit 7 is the OR of the two. Mode 1 raises no request.
- R9: A control write with mode 0 empties the FIFO, drops a read in flight and clears status bits 10:7 from the next cycle. No memory access follows it.
- R10: `data_wr` is ignored in modes 0 and 3, and `data_rd` is ignored in modes 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control value; bits 5:4 mode, bits 5:0 mirrored |
| addr_wr | input | 1 | Start address write strobe |
| addr_wdata | input | 16 | Start address in 8-byte units |
| data_wr | input | 1 | Push strobe for write modes |
| data_wdata | input | 16 | Halfword to push |
| data_rd | input | 1 | Pop strobe for read mode |
| data_rdata | output | 16 | Oldest FIFO entry |
| status | output | 16 | Status word |
| ram_en | output | 1 | Memory access strobe |
| ram_we | output | 1 | Memory write enable |
| ram_addr | output | 18 | Halfword memory address |
| ram_wdata | output | 16 | Memory write data |
| ram_rdata | input | 16 | Memory read data, valid one cycle after a read |

## Verification
If the FIFO occupancy is wrong, it shows within one cycle in the busy and request bits. Halfwords then appear at the wrong memory address or the wrong pop position. This becomes visible at the next paced access, at most 32 cycles later. If the pacing counter is wrong, the spacing between `ram_en` strobes changes right away. If the address register is wrong, the written memory image differs from the pushed sequence, or the data read back differs from what the memory holds. The bench compares full memory images, pop sequences and strobe timestamps against values computed from the start address and the push order.

// File: rtl/sndram_xfer_pkg.sv
package sndram_xfer_pkg;

   typedef enum logic [1:0] {
      XM_STOP    = 2'd0,
      XM_HOST_WR = 2'd1,
      XM_DMA_WR  = 2'd2,
      XM_DMA_RD  = 2'd3
   } xfer_mode_e;

   localparam int ST_W        = 16;
   localparam int ST_BUSY     = 10;
   localparam int ST_WREQ     = 9;
   localparam int ST_RREQ     = 8;
   localparam int ST_ANYREQ   = 7;
   localparam int MIRROR_W    = 6;
   localparam int MODE_LSB    = 4;

   function automatic logic is_wr_mode(input xfer_mode_e m);
      return (m == XM_HOST_WR) || (m == XM_DMA_WR);
   endfunction

endpackage

// File: rtl/sndram_fifo.sv
module sndram_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 32,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);

   logic do_push;
   logic do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else begin
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (do_push) slot <= wdata;
         end
         assign rdata = slot;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [W-1:0]  mem [DEPTH];
         logic [PW-1:0] wp;
         logic [PW-1:0] rp;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp <= '0;
               rp <= '0;
            end else if (clr) begin
               wp <= '0;
               rp <= '0;
            end else begin
               if (do_push) wp <= wp + PW'(1);
               if (do_pop)  rp <= rp + PW'(1);
            end
         end

         always_ff @(posedge clk) begin
            if (do_push && !clr) mem[wp] <= wdata;
         end

         assign rdata = mem[rp];
      end
   endgenerate

endmodule

// File: rtl/sndram_pacer.sv
module sndram_pacer #(
   parameter int TICKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic fire
);

   generate
      if (TICKS == 1) begin : g_every
         logic unused_pacer;
         assign unused_pacer = clk ^ rst_n ^ clr;
         assign fire = run;
      end else begin : g_count
         localparam int CNTW = $clog2(TICKS);
         localparam logic [CNTW-1:0] LAST = CNTW'(TICKS - 1);
         logic [CNTW-1:0] cnt;

         assign fire = run && (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (clr || !run || fire) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + CNTW'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sndram_addr.sv
module sndram_addr #(
   parameter int START_W    = 16,
   parameter int RAM_AW     = 18,
   parameter int UNIT_SHIFT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [START_W-1:0] start,
   input  logic               step,
   output logic [RAM_AW-1:0]  addr
);

   localparam int SW = START_W + UNIT_SHIFT;

   logic [SW-1:0]     scaled;
   logic [RAM_AW-1:0] load_val;

   assign scaled = SW'(start) << UNIT_SHIFT;

   generate
      if (SW >= RAM_AW) begin : g_trunc
         logic unused_hi;
         if (SW > RAM_AW) begin : g_drop
            assign unused_hi = ^scaled[SW-1:RAM_AW];
         end else begin : g_none
            assign unused_hi = 1'b0;
         end
         assign load_val = scaled[RAM_AW-1:0];
      end else begin : g_zext
         assign load_val = RAM_AW'(scaled);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= load_val;
      end else if (step) begin
         addr <= addr + RAM_AW'(1);
      end
   end

endmodule

// File: rtl/sndram_xfer.sv
module sndram_xfer
   import sndram_xfer_pkg::*;
#(
   parameter int DATA_W           = 16,
   parameter int FIFO_DEPTH       = 32,
   parameter int TICKS_PER_HW     = 32,
   parameter int RAM_BYTES        = 512 * 1024,
   parameter int START_W          = 16,
   parameter int START_UNIT_BYTES = 8,
   localparam int RAM_AW          = $clog2(RAM_BYTES / 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [15:0]       ctrl_wdata,
   input  logic              addr_wr,
   input  logic [START_W-1:0] addr_wdata,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_wdata,
   input  logic              data_rd,
   output logic [DATA_W-1:0] data_rdata,
   output logic [15:0]       status,
   output logic              ram_en,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata
);

   localparam int UNIT_SHIFT = $clog2(START_UNIT_BYTES / 2);
   localparam int CW         = $clog2(FIFO_DEPTH + 1);

   generate
      if (FIFO_DEPTH < 1 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two");
      end
      if (TICKS_PER_HW < 1) begin : g_bad_ticks
         $error("TICKS_PER_HW must be at least 1");
      end
      if (RAM_BYTES < 4 || (RAM_BYTES & (RAM_BYTES - 1)) != 0) begin : g_bad_ram
         $error("RAM_BYTES must be a power of two");
      end
      if (START_UNIT_BYTES < 2 || (START_UNIT_BYTES & (START_UNIT_BYTES - 1)) != 0) begin : g_bad_unit
         $error("START_UNIT_BYTES must be a power of two of at least 2");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
   endgenerate

   // Control register: only the mirrored low bits are kept
   logic [MIRROR_W-1:0] ctrl_q;
   xfer_mode_e          mode;
   logic                stop_clr;
   logic                unused_ctrl_hi;

   assign unused_ctrl_hi = ^ctrl_wdata[15:MIRROR_W];
   assign mode     = xfer_mode_e'(ctrl_q[MODE_LSB +: 2]);
   assign stop_clr = ctrl_wr && (ctrl_wdata[MODE_LSB +: 2] == 2'(XM_STOP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= ctrl_wdata[MIRROR_W-1:0];
      end
   end

   // Direction decode
   logic wr_mode;
   logic rd_mode;
   assign wr_mode = is_wr_mode(mode);
   assign rd_mode = (mode == XM_DMA_RD);

   // FIFO
   logic              f_push;
   logic              f_pop;
   logic [DATA_W-1:0] f_wdata;
   logic [DATA_W-1:0] f_head;
   logic              f_empty;
   logic              f_full;
   logic [CW-1:0]     f_count;
   logic              rd_pend;
   logic              fire;

   assign f_push  = (wr_mode && data_wr) || (rd_mode && rd_pend);
   assign f_wdata = wr_mode ? data_wdata : ram_rdata;
   assign f_pop   = (wr_mode && fire) || (rd_mode && data_rd);

   sndram_fifo #(
      .W     (DATA_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (stop_clr),
      .push  (f_push),
      .wdata (f_wdata),
      .pop   (f_pop),
      .rdata (f_head),
      .empty (f_empty),
      .full  (f_full),
      .count (f_count)
   );

   // A read is allowed only if its result will have a slot,
   // counting the one still returning from memory.
   logic room_rd;
   logic run;
   assign room_rd = !f_full && !(rd_pend && (f_count == CW'(FIFO_DEPTH - 1)));
   assign run     = (wr_mode && !f_empty) || (rd_mode && room_rd);

   sndram_pacer #(
      .TICKS (TICKS_PER_HW)
   ) u_pacer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (stop_clr),
      .run   (run),
      .fire  (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
      end else if (stop_clr) begin
         rd_pend <= 1'b0;
      end else begin
         rd_pend <= fire && rd_mode;
      end
   end

   // Memory address
   sndram_addr #(
      .START_W    (START_W),
      .RAM_AW     (RAM_AW),
      .UNIT_SHIFT (UNIT_SHIFT)
   ) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (addr_wr),
      .start (addr_wdata),
      .step  (fire),
      .addr  (ram_addr)
   );

   assign ram_en    = fire;
   assign ram_we    = wr_mode;
   assign ram_wdata = f_head;
   assign data_rdata = f_head;

   // Status word
   logic busy;
   logic wreq;
   logic rreq;
   assign busy = (wr_mode && !f_empty) || (rd_mode && !f_full);
   assign wreq = (mode == XM_DMA_WR) && !f_full;
   assign rreq = rd_mode && !f_empty;

   always_comb begin
      status               = '0;
      status[MIRROR_W-1:0] = ctrl_q;
      status[ST_BUSY]      = busy;
      status[ST_WREQ]      = wreq;
      status[ST_RREQ]      = rreq;
      status[ST_ANYREQ]    = wreq || rreq;
   end

endmodule

// File: rtl/sndram_xfer_chk.sv
module sndram_xfer_chk #(
   parameter int TICKS_PER_HW = 32,
   parameter int RAM_BYTES    = 512 * 1024,
   localparam int RAM_AW      = $clog2(RAM_BYTES / 2),
   localparam int GW          = $clog2(TICKS_PER_HW + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctrl_wr,
   input logic [1:0]        ctrl_mode_wr,
   input logic              addr_wr,
   input logic [3:0]        st_flags,
   input logic [1:0]        st_mode,
   input logic              ram_en,
   input logic              ram_we,
   input logic [RAM_AW-1:0] ram_addr
);

   logic [GW-1:0]     gap;
   logic [RAM_AW-1:0] last_addr;
   logic              have_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap <= GW'(TICKS_PER_HW);
      end else if (ram_en) begin
         gap <= '0;
      end else if (gap != GW'(TICKS_PER_HW)) begin
         gap <= gap + GW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_last <= 1'b0;
         last_addr <= '0;
      end else begin
         if (ram_en) last_addr <= ram_addr;
         if (addr_wr)     have_last <= 1'b0;
         else if (ram_en) have_last <= 1'b1;
      end
   end

   // R4: memory accesses are never closer than the pacing interval
   a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en |-> (gap >= GW'(TICKS_PER_HW - 1)));

   // R5: successive accesses step the address by one, with wrap
   a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && have_last) |-> (ram_addr == last_addr + RAM_AW'(1)));

   // R3: memory direction follows the mode, and nothing happens when stopped
   a_r3_dir: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en |-> ((st_mode != 2'd0) && (ram_we == (st_mode != 2'd3))));

   // R8: each request flag belongs to its own mode
   a_r8_wreq_mode: assert property (@(posedge clk) disable iff (!rst_n)
      st_flags[2] |-> (st_mode == 2'd2));
   a_r8_rreq_mode: assert property (@(posedge clk) disable iff (!rst_n)
      st_flags[1] |-> (st_mode == 2'd3));

   // R9: stopping clears busy and requests and halts memory traffic
   a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && (ctrl_mode_wr == 2'd0)) |=> ((st_flags == 4'd0) && !ram_en));

endmodule

bind sndram_xfer sndram_xfer_chk #(
   .TICKS_PER_HW (TICKS_PER_HW),
   .RAM_BYTES    (RAM_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctrl_wr      (ctrl_wr),
   .ctrl_mode_wr (ctrl_wdata[5:4]),
   .addr_wr      (addr_wr),
   .st_flags     (status[10:7]),
   .st_mode      (status[5:4]),
   .ram_en       (ram_en),
   .ram_we       (ram_we),
   .ram_addr     (ram_addr)
);

// File: tb/sndram_xfer_bench.sv
`timescale 1ns/1ps
module sndram_xfer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [15:0] ctrl_wdata = '0;
   logic        addr_wr = 1'b0;
   logic [15:0] addr_wdata = '0;
   logic        data_wr = 1'b0;
   logic [15:0] data_wdata = '0;
   logic        data_rd = 1'b0;
   logic [15:0] data_rdata;
   logic [15:0] status;
   logic        ram_en;
   logic        ram_we;
   logic [17:0] ram_addr;
   logic [15:0] ram_wdata;
   logic [15:0] ram_rdata = '0;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   int wr_cyc[$];
   logic [15:0] mem [int];

   always #5 clk = ~clk;

   sndram_xfer u_sndram_xfer (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .addr_wr(addr_wr), .addr_wdata(addr_wdata),
      .data_wr(data_wr), .data_wdata(data_wdata),
      .data_rd(data_rd), .data_rdata(data_rdata),
      .status(status),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   function automatic logic [15:0] fval(input int a);
      return a[15:0] ^ 16'h5A5A;
   endfunction

   // Memory model: synchronous, one-cycle read latency
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (ram_en) begin
         if (ram_we) begin
            mem[int'(ram_addr)] = ram_wdata;
            wr_cyc.push_back(cyc);
         end else begin
            ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : fval(int'(ram_addr));
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [15:0] v);
      @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk); ctrl_wr = 1'b0;
   endtask

   task automatic wr_addr(input logic [15:0] v);
      @(negedge clk); addr_wr = 1'b1; addr_wdata = v;
      @(negedge clk); addr_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int push_edge;
      int n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(status == 16'h0000, "R1 status", status, 16'h0000);
      chk(ram_en == 1'b0, "R1 ram_en", ram_en, 0);

      // R2: sweep low bits with mode 0 and junk above bit 5
      for (int k = 0; k < 16; k++) begin
         wr_ctrl({10'h3FF, 2'b00, 4'(k)});
         chk(status == 16'(k), "R2 mirror", status, k);
      end

      // R10: pushes in stopped mode are dropped
      wr_ctrl(16'h0000);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk); data_wr = 1'b1; data_wdata = 16'hC000 + 16'(k);
      end
      @(negedge clk); data_wr = 1'b0;
      n = wr_cyc.size();
      wr_ctrl(16'h0010);
      chk(status == 16'h0010, "R10 stopped push ignored", status, 16'h0010);
      repeat (40) @(negedge clk);
      chk(wr_cyc.size() == n, "R10 no memory write", wr_cyc.size(), n);
      wr_ctrl(16'h0000);

      // R3/R4/R7/R8: DMA write with overflow
      wr_addr(16'h0100);
      wr_ctrl(16'h0020);
      chk(status == 16'h02A0, "R8 dma write idle", status, 16'h02A0);
      wr_cyc.delete();
      push_edge = 0;
      for (int k = 0; k < 34; k++) begin
         @(negedge clk); data_wr = 1'b1; data_wdata = 16'hA000 + 16'(k);
         if (k == 0) push_edge = cyc;
      end
      @(negedge clk); data_wr = 1'b0;
      chk(status == 16'h0420, "R7 R8 full in dma write", status, 16'h0420);
      repeat (1060) @(negedge clk);
      chk(wr_cyc.size() == 33, "R3 accepted count", wr_cyc.size(), 33);
      for (int k = 0; k < 33; k++) begin
         chk(mem.exists(16'h400 + k) && mem[16'h400 + k] == 16'hA000 + 16'(k),
             "R3 R5 memory image", mem.exists(16'h400 + k) ? mem[16'h400 + k] : 16'hxxxx, 16'hA000 + k);
      end
      chk(!mem.exists(16'h421), "R3 overflow dropped", 32'(mem.exists(16'h421)), 0);
      if (wr_cyc.size() == 33) begin
         chk(wr_cyc[0] - push_edge == 32, "R4 first access", wr_cyc[0] - push_edge, 32);
         for (int k = 1; k < 33; k++) begin
            chk(wr_cyc[k] - wr_cyc[k-1] == 32, "R4 spacing", wr_cyc[k] - wr_cyc[k-1], 32);
         end
      end
      chk(status == 16'h02A0, "R7 drained", status, 16'h02A0);

      // R5: wrap at end of memory in host write mode
      wr_ctrl(16'h0010);
      wr_addr(16'hFFFF);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk); data_wr = 1'b1; data_wdata = 16'hB000 + 16'(k);
      end
      @(negedge clk); data_wr = 1'b0;
      chk(status == 16'h0410, "R7 R8 host write busy", status, 16'h0410);
      repeat (240) @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         n = (32'h3FFFC + k) & 32'h3FFFF;
         chk(mem.exists(n) && mem[n] == 16'hB000 + 16'(k), "R5 wrap",
             mem.exists(n) ? mem[n] : 16'hxxxx, 16'hB000 + k);
      end
      chk(status == 16'h0010, "R7 host write idle", status, 16'h0010);

      // R6: DMA read fills from memory
      wr_addr(16'h0200);
      wr_ctrl(16'h0030);
      chk(status == 16'h0430, "R7 read busy", status, 16'h0430);
      repeat (1100) @(negedge clk);
      chk(status == 16'h01B0, "R7 R8 read full", status, 16'h01B0);
      // R10: push ignored in read mode
      @(negedge clk); data_wr = 1'b1; data_wdata = 16'hDEAD;
      @(negedge clk); data_wr = 1'b0;
      chk(status == 16'h01B0, "R10 read mode push ignored", status, 16'h01B0);
      for (int k = 0; k < 32; k++) begin
         @(negedge clk);
         chk(data_rdata == fval(32'h800 + k), "R6 read data", data_rdata, fval(32'h800 + k));
         data_rd = 1'b1;
      end
      @(negedge clk); data_rd = 1'b0;

      // R9: stop flushes
      wr_ctrl(16'h0000);
      chk(status == 16'h0000, "R9 stop status", status, 16'h0000);
      wr_ctrl(16'h0010);
      chk(status == 16'h0010, "R9 fifo flushed", status, 16'h0010);
      n = wr_cyc.size();
      repeat (80) @(negedge clk);
      chk(wr_cyc.size() == n, "R9 no stale write", wr_cyc.size(), n);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule